// File: doc/BRIEF.md
# Floating-Point Sign-Injection and Raw Move Unit

This block executes the double-precision sign-manipulation and raw bit-move operations of a floating-point extension. Each cycle it may accept one 32-bit instruction word with a valid strobe. It also receives two floating-point source operands of register width `FLEN` and one integer source of width `XLEN`. It decodes the word itself and builds a result for either the floating-point or the integer register file. One clock later it presents that result with a write-back strobe and a destination flag.

Sign injection keeps bits 62:0 of the first operand. It forms bit 63 from the second operand's sign, from that sign inverted, or from the XOR of both signs. Results in a floating-point register wider than 64 bits are NaN-boxed, so their upper bits are all ones. The two moves copy raw bits in each direction with no canonicalisation. Any other word under the same major opcode is reported with an illegal-encoding pulse. Words under other opcodes are ignored. The unit never requests an update of the accrued exception flags.

Top module: `fsgn_move_unit`

## Requirements
- R1: An instruction whose bits 6:0 are not 1010011 produces neither `wb_valid` nor `illegal` in the following cycle.
- R2: Function bits 31:25 = 0010001 with bits 14:12 = 000 give result bit 63 equal to bit 63 of `fsrc2`.
- R3: Function bits 31:25 = 0010001 with bits 14:12 = 001 give result bit 63 equal to the inverse of bit 63 of `fsrc2`.
- R4: Function bits 31:25 = 0010001 with bits 14:12 = 010 give result bit 63 equal to the XOR of bit 63 of `fsrc1` and bit 63 of `fsrc2`.
- R5: In every sign-injection variant, result bits 62:0 equal `fsrc1` bits 62:0, including NaN payloads and signalling bits.
- R6: When FLEN > 64, bits FLEN-1:64 of every sign-injection result are all ones. When FLEN = 64, the 64-bit result is written unchanged.
- R7: Function bits 31:25 = 1110001, bits 24:20 = 00000 and bits 14:12 = 000 place `fsrc1` bits 63:0 unchanged on `int_result`, with `wb_to_fp` = 0. The value is sign-extended from bit 63 when XLEN > 64.
- R8: Function bits 31:25 = 1111001, bits 24:20 = 00000 and bits 14:12 = 000 place `isrc` on `fp_result`, zero-extended to FLEN, with `wb_to_fp` = 1.
- R9: An instruction with opcode 1010011 that matches none of the encodings in R2–R4, R7 and R8 raises `illegal` for exactly the next cycle and no `wb_valid`. This covers sign-injection bits 14:12 of 011 through 111, and moves with nonzero bits 24:20 or bits 14:12.
- R10: `wb_valid` rises exactly one clock after an accepted `in_valid`. `wb_to_fp` is 1 for sign injection and for the integer-to-float move, and 0 for the float-to-integer move. Back-to-back inputs give back-to-back results.
- R11: While `rst` is high at a clock edge, `wb_valid` and `illegal` are cleared, whatever `in_valid` carries.
- R12: `fflags_wr` stays 0 on every cycle, so the exception flag bits are never modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| fsrc1 | input | FLEN | First floating-point operand |
| fsrc2 | input | FLEN | Second floating-point operand |
| isrc | input | XLEN | Integer operand |
| wb_valid | output | 1 | Registered write-back strobe |
| wb_to_fp | output | 1 | 1: floating-point destination, 0: integer destination |
| fp_result | output | FLEN | Floating-point write-back value |
| int_result | output | XLEN | Integer write-back value |
| illegal | output | 1 | One-cycle illegal-encoding pulse |
| fflags_wr | output | 1 | Exception-flag update request, always 0 |

## Verification
The bound checker checks the following on every cycle against the inputs one clock earlier:
- bit 63 for each of the three sign rules;
- preservation of bits 62:0;
- the all-ones box;
- both raw moves;
- the exclusivity of write-back and the illegal pulse;
- silence on foreign opcodes.

Three things can only be shown through the bench's scenarios:
- that an illegal pulse appears only for the right malformed words, such as reserved variant codes and moves with stray fields;
- that a sequence of mixed back-to-back instructions lands in order;
- that reset suppresses results while inputs keep arriving.

// File: rtl/fsgn_pkg.sv
package fsgn_pkg;

  localparam logic [6:0] OPC_FP  = 7'b1010011;
  localparam logic [6:0] F7_SGNJ = 7'b0010001;
  localparam logic [6:0] F7_F2I  = 7'b1110001;
  localparam logic [6:0] F7_I2F  = 7'b1111001;

  typedef enum logic [2:0] {
    K_NONE,
    K_SGN_COPY,
    K_SGN_NEG,
    K_SGN_XOR,
    K_FP2INT,
    K_INT2FP
  } fsgn_kind_e;

  typedef struct packed {
    fsgn_kind_e kind;
    logic       ours;
    logic       bad;
  } fsgn_dec_t;

  function automatic logic sign_rule(input fsgn_kind_e k, input logic s1, input logic s2);
    case (k)
      K_SGN_COPY: return s2;
      K_SGN_NEG:  return ~s2;
      K_SGN_XOR:  return s1 ^ s2;
      default:    return s1;
    endcase
  endfunction

  function automatic logic [63:0] inject(input fsgn_kind_e k, input logic [63:0] a, input logic [63:0] b);
    return {sign_rule(k, a[63], b[63]), a[62:0]};
  endfunction

endpackage

// File: rtl/fsgn_decode.sv
module fsgn_decode
  import fsgn_pkg::*;
(
  input  logic [31:0] instr,
  output fsgn_dec_t   dec
);
  logic [6:0] f7;
  logic [4:0] sel2;
  logic [2:0] mode;
  logic       opc_hit;

  assign f7      = instr[31:25];
  assign sel2    = instr[24:20];
  assign mode    = instr[14:12];
  assign opc_hit = (instr[6:0] == OPC_FP);

  always_comb begin
    dec.kind = K_NONE;
    if (opc_hit) begin
      if (f7 == F7_SGNJ) begin
        case (mode)
          3'b000:  dec.kind = K_SGN_COPY;
          3'b001:  dec.kind = K_SGN_NEG;
          3'b010:  dec.kind = K_SGN_XOR;
          default: dec.kind = K_NONE;
        endcase
      end else if (f7 == F7_F2I && sel2 == 5'd0 && mode == 3'b000) begin
        dec.kind = K_FP2INT;
      end else if (f7 == F7_I2F && sel2 == 5'd0 && mode == 3'b000) begin
        dec.kind = K_INT2FP;
      end
    end
    dec.ours = opc_hit;
    dec.bad  = opc_hit && (dec.kind == K_NONE);
  end
endmodule

// File: rtl/fsgn_datapath.sv
module fsgn_datapath
  import fsgn_pkg::*;
#(
  parameter int FLEN = 128,
  parameter int XLEN = 64
) (
  input  fsgn_kind_e        kind,
  input  logic [FLEN-1:0]   fsrc1,
  input  logic [FLEN-1:0]   fsrc2,
  input  logic [XLEN-1:0]   isrc,
  output logic [FLEN-1:0]   fp_res,
  output logic [XLEN-1:0]   int_res,
  output logic              to_fp
);
  localparam int BOX_W = (FLEN > 64) ? FLEN - 64 : 1;

  logic [63:0]     sgn64;
  logic [FLEN-1:0] sgn_boxed;
  logic [FLEN-1:0] i2f_val;

  assign sgn64 = inject(kind, fsrc1[63:0], fsrc2[63:0]);

  generate
    if (FLEN > 64) begin : g_box
      assign sgn_boxed = {{BOX_W{1'b1}}, sgn64};
    end else begin : g_nobox
      assign sgn_boxed = sgn64[FLEN-1:0];
    end

    if (FLEN >= XLEN) begin : g_i2f_zext
      assign i2f_val = {{(FLEN-XLEN){1'b0}}, isrc};
    end else begin : g_i2f_trunc
      assign i2f_val = isrc[FLEN-1:0];
    end

    if (XLEN > 64) begin : g_f2i_sext
      assign int_res = {{(XLEN-64){fsrc1[63]}}, fsrc1[63:0]};
    end else begin : g_f2i_fit
      assign int_res = fsrc1[XLEN-1:0];
    end
  endgenerate

  assign fp_res = (kind == K_INT2FP) ? i2f_val : sgn_boxed;
  assign to_fp  = (kind != K_FP2INT);
endmodule

// File: rtl/fsgn_move_unit.sv
module fsgn_move_unit
  import fsgn_pkg::*;
#(
  parameter int FLEN = 128,
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [FLEN-1:0]   fsrc1,
  input  logic [FLEN-1:0]   fsrc2,
  input  logic [XLEN-1:0]   isrc,
  output logic              wb_valid,
  output logic              wb_to_fp,
  output logic [FLEN-1:0]   fp_result,
  output logic [XLEN-1:0]   int_result,
  output logic              illegal,
  output logic              fflags_wr
);
  fsgn_dec_t       dec;
  logic [FLEN-1:0] fp_next;
  logic [XLEN-1:0] int_next;
  logic            to_fp_next;
  logic            ev_accept;
  logic            ev_reject;

  fsgn_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  fsgn_datapath #(.FLEN(FLEN), .XLEN(XLEN)) u_dp (
    .kind    (dec.kind),
    .fsrc1   (fsrc1),
    .fsrc2   (fsrc2),
    .isrc    (isrc),
    .fp_res  (fp_next),
    .int_res (int_next),
    .to_fp   (to_fp_next)
  );

  // named events for the checker
  assign ev_accept = in_valid && dec.ours && !dec.bad;
  assign ev_reject = in_valid && dec.bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      wb_valid <= ev_accept;
      illegal  <= ev_reject;
    end
  end

  always_ff @(posedge clk) begin
    if (ev_accept) begin
      wb_to_fp   <= to_fp_next;
      fp_result  <= fp_next;
      int_result <= int_next;
    end
  end

  assign fflags_wr = 1'b0;
endmodule

// File: rtl/fsgn_move_unit_chk.sv
module fsgn_move_unit_chk
  import fsgn_pkg::*;
#(
  parameter int FLEN = 128,
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     instr,
  input logic [FLEN-1:0] fsrc1,
  input logic [FLEN-1:0] fsrc2,
  input logic [XLEN-1:0] isrc,
  input logic            wb_valid,
  input logic            wb_to_fp,
  input logic [FLEN-1:0] fp_result,
  input logic [XLEN-1:0] int_result,
  input logic            illegal,
  input logic            ev_accept,
  input logic            ev_reject
);
  localparam int LO_F2I = (XLEN < 64) ? XLEN : 64;
  localparam int LO_I2F = (XLEN < FLEN) ? XLEN : FLEN;

  p_foreign_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid && instr[6:0] != OPC_FP |=> !wb_valid && !illegal);

  p_copy_r2: assert property (@(posedge clk) disable iff (rst)
    wb_valid && $past(instr[31:25]) == F7_SGNJ && $past(instr[14:12]) == 3'b000
      |-> fp_result[63] == $past(fsrc2[63]));

  p_neg_r3: assert property (@(posedge clk) disable iff (rst)
    wb_valid && $past(instr[31:25]) == F7_SGNJ && $past(instr[14:12]) == 3'b001
      |-> fp_result[63] == !$past(fsrc2[63]));

  p_xor_r4: assert property (@(posedge clk) disable iff (rst)
    wb_valid && $past(instr[31:25]) == F7_SGNJ && $past(instr[14:12]) == 3'b010
      |-> fp_result[63] == ($past(fsrc1[63]) ^ $past(fsrc2[63])));

  p_keep_r5: assert property (@(posedge clk) disable iff (rst)
    wb_valid && $past(instr[31:25]) == F7_SGNJ |-> fp_result[62:0] == $past(fsrc1[62:0]));

  generate
    if (FLEN > 64) begin : g_box_chk
      p_box_r6: assert property (@(posedge clk) disable iff (rst)
        wb_valid && $past(instr[31:25]) == F7_SGNJ |-> &fp_result[FLEN-1:64]);
    end
  endgenerate

  p_f2i_r7: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_to_fp |-> int_result[LO_F2I-1:0] == $past(fsrc1[LO_F2I-1:0]));

  p_i2f_r8: assert property (@(posedge clk) disable iff (rst)
    wb_valid && $past(instr[31:25]) == F7_I2F
      |-> wb_to_fp && fp_result[LO_I2F-1:0] == $past(isrc[LO_I2F-1:0]));

  p_illegal_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wb_valid && $past(in_valid) && $past(instr[6:0]) == OPC_FP);

  p_reject_r9: assert property (@(posedge clk) disable iff (rst)
    ev_reject |=> illegal);

  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    ev_accept |=> wb_valid);

  p_origin_r10: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(in_valid));

  p_reset_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wb_valid && !illegal);
endmodule

bind fsgn_move_unit fsgn_move_unit_chk #(.FLEN(FLEN), .XLEN(XLEN)) u_chk (.*);

// File: tb/test_fsgn_move_unit.sv
module test_fsgn_move_unit;
  localparam int FLEN = 128;
  localparam int XLEN = 64;

  typedef struct {
    int          kind;   // 0 write-back, 1 illegal, 2 silent
    logic        to_fp;
    logic [127:0] fp;
    logic [63:0]  iv;
    string        req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [31:0]      instr = '0;
  logic [FLEN-1:0]  fsrc1 = '0;
  logic [FLEN-1:0]  fsrc2 = '0;
  logic [XLEN-1:0]  isrc = '0;
  logic             wb_valid, wb_to_fp, illegal, fflags_wr;
  logic [FLEN-1:0]  fp_result;
  logic [XLEN-1:0]  int_result;

  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  fsgn_move_unit #(.FLEN(FLEN), .XLEN(XLEN)) i_fsgn_move_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .fsrc1(fsrc1), .fsrc2(fsrc2), .isrc(isrc),
    .wb_valid(wb_valid), .wb_to_fp(wb_to_fp), .fp_result(fp_result),
    .int_result(int_result), .illegal(illegal), .fflags_wr(fflags_wr)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] s2,
                                     input logic [2:0] md, input logic [6:0] opc);
    return {f7, s2, 5'd3, md, 5'd9, opc};
  endfunction

  // expected model written from the requirements
  task automatic issue(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b,
                       input logic [63:0] iv_in);
    exp_t e;
    logic sgn;
    e.kind = 2; e.to_fp = 1'b0; e.fp = '0; e.iv = '0; e.req = "R1";
    if (w[6:0] == 7'b1010011) begin
      e.kind = 1; e.req = "R9";
      if (w[31:25] == 7'b0010001 && w[14:12] <= 3'b010) begin
        sgn = (w[14:12] == 3'b000) ? b[63] : (w[14:12] == 3'b001) ? !b[63] : (a[63] ^ b[63]);
        e.kind = 0; e.to_fp = 1'b1;
        e.fp = {64'hFFFF_FFFF_FFFF_FFFF, sgn, a[62:0]};
        e.req = (w[14:12] == 3'b000) ? "R2/R5/R6" : (w[14:12] == 3'b001) ? "R3/R5/R6" : "R4/R5/R6";
      end else if (w[31:25] == 7'b1110001 && w[24:20] == 5'd0 && w[14:12] == 3'b000) begin
        e.kind = 0; e.to_fp = 1'b0; e.iv = a[63:0]; e.req = "R7";
      end else if (w[31:25] == 7'b1111001 && w[24:20] == 5'd0 && w[14:12] == 3'b000) begin
        e.kind = 0; e.to_fp = 1'b1; e.fp = {64'd0, iv_in}; e.req = "R8";
      end
    end
    @(negedge clk);
    in_valid = 1'b1; instr = w; fsrc1 = a; fsrc2 = b; isrc = iv_in;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops one expectation per accepted input cycle
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        chk(fflags_wr == 1'b0, "R12", fflags_wr, 0);
        if (q.size() > 0) begin
          it = q.pop_front();
          if (it.kind == 0) begin
            chk(wb_valid == 1'b1, {"R10 valid ", it.req}, wb_valid, 1);
            chk(illegal == 1'b0, {"R10 no-illegal ", it.req}, illegal, 0);
            chk(wb_to_fp == it.to_fp, {"R10 dest ", it.req}, wb_to_fp, it.to_fp);
            if (it.to_fp) chk(fp_result == it.fp, it.req, fp_result, it.fp);
            else          chk(int_result == it.iv, it.req, int_result, it.iv);
          end else if (it.kind == 1) begin
            chk(illegal == 1'b1, "R9 pulse", illegal, 1);
            chk(wb_valid == 1'b0, "R9 no write-back", wb_valid, 0);
          end else begin
            chk(wb_valid == 1'b0 && illegal == 1'b0, "R1 foreign opcode", {wb_valid, illegal}, 0);
          end
        end else begin
          chk(wb_valid == 1'b0 && illegal == 1'b0, "R9/R10 idle low", {wb_valid, illegal}, 0);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [6:0] OP = 7'b1010011;
  localparam logic [127:0] POS = 128'h0123_4567_89AB_CDEF_3FF8_0000_0000_0001;
  localparam logic [127:0] NEG = 128'hAAAA_0000_5555_1111_C00F_FFFF_0000_1234;
  localparam logic [127:0] SNAN = 128'h0000_0000_0000_0000_7FF4_0000_DEAD_BEEF;

  initial begin
    // R11: reset dominates a valid legal input
    in_valid = 1'b1; instr = mk(7'b0010001, 5'd4, 3'b000, OP); fsrc1 = POS; fsrc2 = NEG;
    repeat (3) @(posedge clk);
    #1;
    chk(wb_valid == 1'b0, "R11 wb_valid in reset", wb_valid, 0);
    chk(illegal == 1'b0, "R11 illegal in reset", illegal, 0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0; mon_on = 1'b1;
    idle(2);

    // R2 R3 R4 R5 R6 sign variants with both sign combinations
    issue(mk(7'b0010001, 5'd4, 3'b000, OP), POS, NEG, '0);
    issue(mk(7'b0010001, 5'd4, 3'b000, OP), NEG, POS, '0);
    issue(mk(7'b0010001, 5'd4, 3'b001, OP), POS, NEG, '0);
    issue(mk(7'b0010001, 5'd4, 3'b001, OP), POS, POS, '0);
    issue(mk(7'b0010001, 5'd4, 3'b010, OP), NEG, NEG, '0);
    issue(mk(7'b0010001, 5'd4, 3'b010, OP), NEG, POS, '0);
    idle(1);
    // R5: signalling NaN payload untouched
    issue(mk(7'b0010001, 5'd4, 3'b001, OP), SNAN, POS, '0);
    // R7 / R8 raw moves
    issue(mk(7'b1110001, 5'd0, 3'b000, OP), NEG, POS, '0);
    issue(mk(7'b1111001, 5'd0, 3'b000, OP), POS, NEG, 64'hFFF8_0000_0000_0042);
    issue(mk(7'b1110001, 5'd0, 3'b000, OP), SNAN, POS, '0);
    idle(2);
    // R9 reserved variants and malformed moves
    issue(mk(7'b0010001, 5'd4, 3'b011, OP), POS, NEG, '0);
    issue(mk(7'b0010001, 5'd4, 3'b111, OP), POS, NEG, '0);
    issue(mk(7'b1110001, 5'd1, 3'b000, OP), POS, NEG, '0);
    issue(mk(7'b1111001, 5'd0, 3'b001, OP), POS, NEG, 64'h1);
    issue(mk(7'b0000001, 5'd4, 3'b000, OP), POS, NEG, '0);
    idle(1);
    // R1 foreign opcodes, including one whose upper fields look like a move
    issue(mk(7'b0010001, 5'd4, 3'b000, 7'b0110011), POS, NEG, '0);
    issue(mk(7'b1111001, 5'd0, 3'b000, 7'b1010111), POS, NEG, 64'h5);
    // R10 mixed back-to-back stream
    issue(mk(7'b1111001, 5'd0, 3'b000, OP), POS, NEG, 64'h8000_0000_0000_0001);
    issue(mk(7'b0010001, 5'd4, 3'b010, OP), POS, NEG, '0);
    issue(mk(7'b0010001, 5'd4, 3'b110, OP), POS, NEG, '0);
    issue(mk(7'b1110001, 5'd0, 3'b000, OP), POS, NEG, '0);
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule